// File: doc/BRIEF.md
# USB Endpoint IN-FIFO DMA Request Generator

This block raises DMA request pulses for a set of DMA channels that fill the IN FIFOs of USB endpoints 1 to 4. Each channel has its own select register. Software writes the register through a per-channel write strobe on a shared data bus, and the register names the one endpoint that the channel serves. Each channel also has an enable input. The block watches three things for every endpoint: the two-bit IN buffer status, a status-update strobe from the USB engine, and the FIFO write strobe driven by the DMA controller.

A channel requests transfers in three ways:
- When the buffer status of its endpoint is updated to a value that means fresh packet space.
- When it is given an endpoint while it previously had none, and that endpoint already has space.
- Once for every unit written into its endpoint's FIFO while space remains.

In practice, the first of these three starts the first word of a buffer, and the FIFO-write trigger then paces each later word. A write counts as one unit whatever the transfer width. The block also raises a per-endpoint IN interrupt when the engine reports a completed packet together with a status update.

Each channel runs a three-state machine:
- `CH_EMPTY`: the select register is all zeros.
- `CH_ARMED`: exactly one bit is set.
- `CH_BAD`: more than one bit is set.

Any select write moves the channel to the state that matches the written value: zero goes to `CH_EMPTY`, one bit to `CH_ARMED`, several bits to `CH_BAD`. Reset returns every channel to `CH_EMPTY`. Requests and interrupts are registered, so each appears in the cycle after the event that causes it.

Top module: `usbdma_req_gen`

## Requirements
- R1: Reset drives all requests and interrupts low, returns every select register to empty (`CH_EMPTY`), and no request is produced while reset is held.
- R2: A channel produces a request only if its enable input was 1 in the event cycle.
- R3: Select data bit k names endpoint k+1. A channel holding zero bits or more than one bit set (`CH_BAD`) never requests.
- R4: An endpoint has room when its status is 00, or when its status is 01 and the endpoint is in double-buffer mode. Statuses 10 and 11 never give room.
- R5: A status-update strobe on the selected endpoint requests when the new status is 00 in single-buffer mode or 01 in double-buffer mode. Any other value does not request.
- R6: A select write that names one endpoint into a channel that was in `CH_EMPTY` requests if that endpoint has room. A write into a non-empty channel does not request.
- R7: Each FIFO write strobe on the selected endpoint while it has room produces one request, including on consecutive cycles.
- R8: When several triggers coincide for one channel, exactly one single-cycle pulse is produced.
- R9: The endpoint interrupt pulses in the cycle after a status update that carries packet-done, and only then. This is the same cycle as any status-update request.
- R10: Channels act independently. Two channels that select the same endpoint both request on its events.
- R11: With no FIFO write, status update or select write in a cycle, no request follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_enable | input | NCH | Per-channel DMA enable |
| sel_wr | input | NCH | Per-channel select register write strobe |
| sel_wdata | input | NEP | Shared select write data, bit k = endpoint k+1 |
| ep_stat | input | 2*NEP | IN buffer status, endpoint k at bits [2k+1:2k] |
| ep_stat_upd | input | NEP | Status-update strobe per endpoint |
| ep_dbl | input | NEP | Double-buffer mode per endpoint |
| ep_pkt_done | input | NEP | Packet completed, with the status update |
| fifo_wr | input | NEP | IN FIFO write strobe per endpoint |
| dma_req | output | NCH | Single-cycle DMA request per channel |
| ep_irq | output | NEP | Endpoint IN interrupt pulse |

## Verification
The bench tests each trigger with the endpoint status set so that it both permits and forbids a request:
- Status 01 is tried in single-buffer and in double-buffer mode, which separates the room rule from the status-update rule.
- Select writes go into empty, armed and invalid registers, which shows that the selection trigger depends on the previous register content and not on the new value alone.
- Coincident status-update and FIFO-write triggers, repeated FIFO writes and two channels sharing one endpoint separate pulse merging from per-event pacing.
- A mid-run reset followed by writes checks that the selections were really cleared.

// File: rtl/usbdma_pkg.sv
package usbdma_pkg;

    typedef enum logic [1:0] {
        CH_EMPTY = 2'd0,
        CH_ARMED = 2'd1,
        CH_BAD   = 2'd2
    } ch_state_e;

    localparam logic [1:0] STAT_FREE = 2'b00;
    localparam logic [1:0] STAT_HALF = 2'b01;

    // Space for at least one packet.
    function automatic logic stat_has_room(input logic [1:0] st, input logic dbl);
        return (st == STAT_FREE) || (dbl && (st == STAT_HALF));
    endfunction

    // Value a status update must carry to start a buffer.
    function automatic logic stat_fill_start(input logic [1:0] st, input logic dbl);
        return dbl ? (st == STAT_HALF) : (st == STAT_FREE);
    endfunction

endpackage

// File: rtl/usbdma_ep_watch.sv
module usbdma_ep_watch
    import usbdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] stat,
    input  logic       stat_upd,
    input  logic       dbl,
    input  logic       pkt_done,
    input  logic       wr_stb,
    output logic       room,
    output logic       upd_hit,
    output logic       wr_hit,
    output logic       irq
);

    logic irq_q;

    always_comb begin
        room    = stat_has_room(stat, dbl);
        upd_hit = stat_upd && stat_fill_start(stat, dbl);
        wr_hit  = wr_stb && room;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= stat_upd && pkt_done;
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/usbdma_chan.sv
module usbdma_chan
    import usbdma_pkg::*;
#(
    parameter int NEP = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           sel_wr,
    input  logic [NEP-1:0] sel_wdata,
    input  logic [NEP-1:0] room_vec,
    input  logic [NEP-1:0] upd_vec,
    input  logic [NEP-1:0] wr_vec,
    output logic           req
);

    ch_state_e      state_q, state_d;
    logic [NEP-1:0] sel_q, sel_d;
    logic           wdata_one, wdata_zero;
    logic           trig_upd, trig_sel, trig_wr;
    logic           req_d, req_q;

    always_comb begin
        wdata_zero = (sel_wdata == '0);
        wdata_one  = !wdata_zero && ((sel_wdata & (sel_wdata - 1'b1)) == '0);
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        if (sel_wr) begin
            sel_d = sel_wdata;
            unique case (1'b1)
                wdata_zero: state_d = CH_EMPTY;
                wdata_one:  state_d = CH_ARMED;
                default:    state_d = CH_BAD;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_EMPTY;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    // Outputs: the three trigger conditions.
    always_comb begin
        trig_upd = 1'b0;
        trig_sel = 1'b0;
        trig_wr  = 1'b0;
        unique case (state_q)
            CH_EMPTY: begin
                trig_sel = sel_wr && wdata_one && ((sel_wdata & room_vec) != '0);
            end
            CH_ARMED: begin
                trig_upd = (sel_q & upd_vec) != '0;
                trig_wr  = (sel_q & wr_vec)  != '0;
            end
            CH_BAD: begin
                trig_upd = 1'b0;
            end
            default: begin
                trig_upd = 1'b0;
            end
        endcase
        req_d = en && (trig_upd || trig_sel || trig_wr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= req_d;
        end
    end

    assign req = req_q;

endmodule

// File: rtl/usbdma_req_gen.sv
module usbdma_req_gen
    import usbdma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int NEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   ch_enable,
    input  logic [NCH-1:0]   sel_wr,
    input  logic [NEP-1:0]   sel_wdata,
    input  logic [2*NEP-1:0] ep_stat,
    input  logic [NEP-1:0]   ep_stat_upd,
    input  logic [NEP-1:0]   ep_dbl,
    input  logic [NEP-1:0]   ep_pkt_done,
    input  logic [NEP-1:0]   fifo_wr,
    output logic [NCH-1:0]   dma_req,
    output logic [NEP-1:0]   ep_irq
);

    logic [NEP-1:0] room_vec;
    logic [NEP-1:0] upd_vec;
    logic [NEP-1:0] wr_vec;

    for (genvar e = 0; e < NEP; e++) begin : g_ep
        usbdma_ep_watch i_watch (
            .clk      (clk),
            .rst_n    (rst_n),
            .stat     (ep_stat[2*e +: 2]),
            .stat_upd (ep_stat_upd[e]),
            .dbl      (ep_dbl[e]),
            .pkt_done (ep_pkt_done[e]),
            .wr_stb   (fifo_wr[e]),
            .room     (room_vec[e]),
            .upd_hit  (upd_vec[e]),
            .wr_hit   (wr_vec[e]),
            .irq      (ep_irq[e])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        usbdma_chan #(.NEP(NEP)) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (ch_enable[c]),
            .sel_wr    (sel_wr[c]),
            .sel_wdata (sel_wdata),
            .room_vec  (room_vec),
            .upd_vec   (upd_vec),
            .wr_vec    (wr_vec),
            .req       (dma_req[c])
        );
    end

endmodule

// File: rtl/usbdma_req_gen_chk.sv
module usbdma_req_gen_chk #(
    parameter int NCH = 4,
    parameter int NEP = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] ch_enable,
    input logic [NCH-1:0] sel_wr,
    input logic [NEP-1:0] ep_stat_upd,
    input logic [NEP-1:0] ep_pkt_done,
    input logic [NEP-1:0] fifo_wr,
    input logic [NCH-1:0] dma_req,
    input logic [NEP-1:0] ep_irq
);

    for (genvar c = 0; c < NCH; c++) begin : g_c
        p_req_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_enable[c] |=> !dma_req[c]);
    end

    p_no_event_no_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr == '0 && ep_stat_upd == '0 && sel_wr == '0) |=> (dma_req == '0));

    for (genvar e = 0; e < NEP; e++) begin : g_e
        p_irq_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (ep_stat_upd[e] && ep_pkt_done[e]) |=> ep_irq[e]);
        p_irq_only_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !(ep_stat_upd[e] && ep_pkt_done[e]) |=> !ep_irq[e]);
    end

endmodule

bind usbdma_req_gen usbdma_req_gen_chk #(.NCH(NCH), .NEP(NEP)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ch_enable   (ch_enable),
    .sel_wr      (sel_wr),
    .ep_stat_upd (ep_stat_upd),
    .ep_pkt_done (ep_pkt_done),
    .fifo_wr     (fifo_wr),
    .dma_req     (dma_req),
    .ep_irq      (ep_irq)
);

// File: tb/test_usbdma_req_gen.sv
module test_usbdma_req_gen;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int NEP = 4;

    typedef struct packed {
        logic [3:0] en;
        logic [3:0] swr;
        logic [3:0] swd;
        logic [7:0] stat;
        logic [3:0] upd;
        logic [3:0] dbl;
        logic [3:0] pkt;
        logic [3:0] fwr;
        logic [3:0] ereq;
        logic [3:0] eirq;
        logic [3:0] tag;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{4'hF, 4'h1, 4'h1, 8'hAA, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'd4},  // R4 select EP1, status full
        '{4'hF, 4'h0, 4'h0, 8'hAA, 4'h0, 4'h0, 4'h0, 4'h1, 4'h0, 4'h0, 4'd4},  // R4 write without room
        '{4'hF, 4'h0, 4'h0, 8'hA8, 4'h1, 4'h0, 4'h1, 4'h0, 4'h1, 4'h1, 4'd5},  // R5 R9 update to 00
        '{4'hF, 4'h0, 4'h0, 8'hA8, 4'h0, 4'h0, 4'h0, 4'h1, 4'h1, 4'h0, 4'd7},  // R7 write paced
        '{4'hF, 4'h0, 4'h0, 8'hA8, 4'h0, 4'h0, 4'h0, 4'h1, 4'h1, 4'h0, 4'd7},  // R7 back to back
        '{4'hE, 4'h0, 4'h0, 8'hA8, 4'h0, 4'h0, 4'h0, 4'h1, 4'h0, 4'h0, 4'd2},  // R2 disabled
        '{4'hF, 4'h2, 4'h2, 8'hA0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h2, 4'h0, 4'd6},  // R6 empty select
        '{4'hF, 4'h2, 4'h2, 8'hA0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'd6},  // R6 rewrite armed
        '{4'hF, 4'h4, 4'h6, 8'h80, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'd3},  // R3 two bits
        '{4'hF, 4'h0, 4'h0, 8'h80, 4'h0, 4'h0, 4'h0, 4'h6, 4'h2, 4'h0, 4'd3},  // R3 invalid silent
        '{4'hF, 4'h8, 4'h8, 8'h40, 4'h0, 4'h8, 4'h0, 4'h0, 4'h8, 4'h0, 4'd4},  // R4 01 double room
        '{4'hF, 4'h0, 4'h0, 8'h40, 4'h0, 4'h0, 4'h0, 4'h8, 4'h0, 4'h0, 4'd4},  // R4 01 single no room
        '{4'hF, 4'h0, 4'h0, 8'h00, 4'h8, 4'h8, 4'h0, 4'h0, 4'h0, 4'h0, 4'd5},  // R5 double needs 01
        '{4'hF, 4'h0, 4'h0, 8'h40, 4'h8, 4'h8, 4'h8, 4'h8, 4'h8, 4'h8, 4'd8},  // R8 R9 merge
        '{4'hF, 4'h0, 4'h0, 8'h40, 4'h0, 4'h8, 4'h0, 4'h0, 4'h0, 4'h0, 4'd11}, // R11 R8 one cycle
        '{4'hF, 4'h1, 4'h0, 8'h40, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'd3},  // R3 clear select
        '{4'hF, 4'h1, 4'h1, 8'h40, 4'h0, 4'h0, 4'h0, 4'h0, 4'h1, 4'h0, 4'd6},  // R6 reselect
        '{4'hF, 4'h4, 4'h1, 8'h40, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'd6},  // R6 from invalid
        '{4'hF, 4'h0, 4'h0, 8'h40, 4'h0, 4'h0, 4'h0, 4'h1, 4'h5, 4'h0, 4'd10}, // R10 shared EP1
        '{4'hF, 4'h0, 4'h0, 8'h40, 4'h1, 4'h0, 4'h0, 4'h0, 4'h5, 4'h0, 4'd10}  // R10 R5 no irq
    };

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] ch_enable;
    logic [NCH-1:0] sel_wr;
    logic [NEP-1:0] sel_wdata;
    logic [7:0]     ep_stat;
    logic [NEP-1:0] ep_stat_upd, ep_dbl, ep_pkt_done, fifo_wr;
    logic [NCH-1:0] dma_req;
    logic [NEP-1:0] ep_irq;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    usbdma_req_gen #(.NCH(NCH), .NEP(NEP)) i_usbdma_req_gen (
        .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .sel_wr(sel_wr),
        .sel_wdata(sel_wdata), .ep_stat(ep_stat), .ep_stat_upd(ep_stat_upd),
        .ep_dbl(ep_dbl), .ep_pkt_done(ep_pkt_done), .fifo_wr(fifo_wr),
        .dma_req(dma_req), .ep_irq(ep_irq)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ch_enable = 4'hF; sel_wr = '0; sel_wdata = '0; ep_stat = 8'hAA;
        ep_stat_upd = '0; ep_dbl = '0; ep_pkt_done = '0; fifo_wr = '0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        fifo_wr = 4'h1;
        repeat (3) @(negedge clk);
        check("R1 req in reset", dma_req, 4'h0);
        check("R1 irq in reset", ep_irq, 4'h0);
        fifo_wr = '0;
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            ch_enable   = VEC[i].en;
            sel_wr      = VEC[i].swr;
            sel_wdata   = VEC[i].swd;
            ep_stat     = VEC[i].stat;
            ep_stat_upd = VEC[i].upd;
            ep_dbl      = VEC[i].dbl;
            ep_pkt_done = VEC[i].pkt;
            fifo_wr     = VEC[i].fwr;
            @(negedge clk);
            check($sformatf("R%0d vec %0d req", VEC[i].tag, i), dma_req, VEC[i].ereq);
            check($sformatf("R%0d vec %0d irq", VEC[i].tag, i), ep_irq, VEC[i].eirq);
        end

        // R1: mid-run reset clears selections.
        idle_inputs();
        rst_n = 1'b0;
        ep_stat = 8'h00;
        fifo_wr = 4'hF;
        ep_stat_upd = 4'hF;
        @(negedge clk);
        @(negedge clk);
        check("R1 held reset", dma_req, 4'h0);
        rst_n = 1'b1;
        ep_stat_upd = '0;
        fifo_wr = 4'h1;
        @(negedge clk);
        check("R1 selects cleared", dma_req, 4'h0);
        fifo_wr = '0;
        sel_wr = 4'h1;
        sel_wdata = 4'h1;
        @(negedge clk);
        check("R6 empty after reset", dma_req, 4'h1);
        sel_wr = '0;
        @(negedge clk);
        check("R11 quiet", dma_req, 4'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule